// File: doc/BRIEF.md
# Chained-XOR Memory Self-Test Controller

This controller tests a region of a 32-bit, word-addressed synchronous RAM without comparing every word. It first writes a repeating three-word pattern into the region. It then runs two propagation passes. In each pass every word is rewritten as its stored value XOR the value read back from the word before it in walk order. A defective cell corrupts the chain, and the corruption travels to the far end of the walk. At the end only three words are read and compared, and every differing bit is ORed into a 32-bit bad-bit mask.

The caller gives the first and last word address of the region and a direction bit. The controller walks upward from the first address, or downward from the last address. A one-cycle start pulse launches a run. Busy stays high while the run is in progress. Done pulses once at the end, and the mask stays on its output until the next accepted start.

Control and status pins are plain levels and pulses. The memory port is a plain synchronous RAM port with no handshake. A read issued in one cycle returns its data in the next cycle. The memory can never push back, so no flow control is needed.

Top module: `xorprop_bist`

## Requirements
- R1: The fill writes every word of the region once, in walk order. Walk index k gets the pattern for k mod 3. Pattern 0 is 32'h6DB6DB6D, pattern 1 is 32'hB6DB6DB6 and pattern 2 is 32'hDB6DB6DB.
- R2: Each propagation pass visits the words in walk order. For each word it writes the word's read value XOR a chain value. For the first word the chain value is the seed. For every later word it is the value read back from the previous word after that word was written. The seed is pattern 1 in the first pass and pattern 0 in the second pass.
- R3: Every propagation write goes to the address that was read in the cycle just before it, and it uses that returned data. The last word of a pass is read and written but not read back.
- R4: After both passes, the three words with walk index N-3, N-2 and N-1 are read in that order. Word k is compared with pattern (k+1) mod 3. On a fault-free memory the final mask is zero for every region length mod 3.
- R5: With the direction bit set, walk index k maps to address last-k. The fill and both passes therefore run from the top of the region down, and the check reads the three lowest addresses.
- R6: With faulty cells, the final mask equals the OR of the bitwise differences between the final contents of the three checked words and their expected patterns. A fault earlier in the walk reaches these words through the XOR chain.
- R7: Busy rises in the cycle after an accepted start. Done is high for exactly one cycle, and busy is low while done is high. After that the mask holds its value until the next accepted start.
- R8: A start pulse while busy has no effect. The run in progress keeps its addresses, direction and memory operations.
- R9: The mask reads zero in the first busy cycle. During a run it only gains bits.
- R10: A start is refused when the region has fewer than six words, including when last is below first. After a refused start busy stays low, no memory access is made and the mask keeps its value.
- R11: A run over N words keeps busy high for exactly 7N+4 cycles. That is N fill cycles, 3N-1 cycles per pass and six check cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle run request |
| reverse_i | input | 1 | 1 = walk from last address downward |
| base_i | input | AW | First word address of the region |
| last_i | input | AW | Last word address of the region (inclusive) |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| bad_mask_o | output | 32 | Accumulated bad-bit mask |
| mem_en_o | output | 1 | Memory access enable |
| mem_we_o | output | 1 | Memory write enable (read when low) |
| mem_addr_o | output | AW | Memory word address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, valid one cycle after a read |

## Verification
Fault-free runs cover region lengths of six, seven and eight words in the upward direction, one for each value of N mod 3. This shows whether the check rotates the expected patterns correctly for each phase. Downward runs with eight and nine words show whether the address mapping and the choice of checked words are mirrored. Stuck-at faults are injected in the last word and in a word near the start of a downward walk. These separate a direct hit from a fault that reaches the checked words only through the XOR chain, and the predicted mask is compared exactly. A start pulse in mid-run, short and inverted regions, and a clean run after a faulty one exercise the acceptance rules and the clearing of the mask.

// File: rtl/xorprop_pkg.sv
package xorprop_pkg;

  localparam int DW = 32;
  localparam int MIN_WORDS = 6;
  localparam int MIN_SPAN = MIN_WORDS - 1;

  localparam logic [DW-1:0] PAT0 = 32'h6DB6DB6D;
  localparam logic [DW-1:0] PAT1 = 32'hB6DB6DB6;
  localparam logic [DW-1:0] PAT2 = 32'hDB6DB6DB;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_PRD,   // propagation read of word k
    ST_PWR,   // propagation write of word k
    ST_PRB,   // read-back of word k, becomes chain value
    ST_CRD,   // check read
    ST_CACC   // check accumulate
  } st_e;

  function automatic logic [DW-1:0] pat_sel(input logic [1:0] idx);
    case (idx)
      2'd0:    return PAT0;
      2'd1:    return PAT1;
      default: return PAT2;
    endcase
  endfunction

  function automatic logic [1:0] mod3_inc(input logic [1:0] idx);
    return (idx == 2'd2) ? 2'd0 : idx + 2'd1;
  endfunction

endpackage

// File: rtl/xp_walker.sv
module xp_walker #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          rev_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] last_i,
  input  logic          clr_i,
  input  logic          tail_i,
  input  logic          step_i,
  output logic [AW-1:0] addr_o,
  output logic          at_end_o
);

  logic [AW-1:0] base_q, last_q, span_q, k_q;
  logic          rev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      last_q <= '0;
      span_q <= '0;
      rev_q  <= 1'b0;
      k_q    <= '0;
    end else if (load_i) begin
      base_q <= base_i;
      last_q <= last_i;
      span_q <= last_i - base_i;
      rev_q  <= rev_i;
      k_q    <= '0;
    end else if (clr_i) begin
      k_q <= '0;
    end else if (tail_i) begin
      k_q <= span_q - AW'(2);
    end else if (step_i) begin
      k_q <= k_q + AW'(1);
    end
  end

  assign addr_o   = rev_q ? (last_q - k_q) : (base_q + k_q);
  assign at_end_o = (k_q == span_q);

  // R5
  addr_in_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_o >= base_q) && (addr_o <= last_q));

endmodule

// File: rtl/xp_mask.sv
module xp_mask #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          acc_i,
  input  logic [DW-1:0] diff_i,
  output logic [DW-1:0] mask_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mask_o <= '0;
    else if (clr_i) mask_o <= '0;
    else if (acc_i) mask_o <= mask_o | diff_i;
  end

  // R9
  mask_grow_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((mask_o & $past(mask_o)) == $past(mask_o)));

  // R9
  mask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (mask_o == '0));

endmodule

// File: rtl/xorprop_bist.sv
module xorprop_bist
  import xorprop_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          reverse_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] last_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] bad_mask_o,
  output logic          mem_en_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i
);

  st_e           st_q;
  logic [1:0]    pidx_q, phase_q, eidx_q;
  logic          pass_q, rb_q, done_q;
  logic [DW-1:0] prev_q;

  logic [AW-1:0] span_in;
  logic          region_ok, accept;
  logic          w_clr, w_tail, w_step, at_end, acc;
  logic [AW-1:0] walk_addr;

  assign span_in   = last_i - base_i;
  assign region_ok = (last_i >= base_i) && (span_in >= AW'(MIN_SPAN));
  assign accept    = (st_q == ST_IDLE) && start_i && region_ok;

  always_comb begin
    w_clr  = 1'b0;
    w_tail = 1'b0;
    w_step = 1'b0;
    acc    = 1'b0;
    unique case (st_q)
      ST_FILL: if (at_end) w_clr = 1'b1; else w_step = 1'b1;
      ST_PWR:  if (at_end) begin
                 if (!pass_q) w_clr = 1'b1; else w_tail = 1'b1;
               end
      ST_PRB:  w_step = 1'b1;
      ST_CACC: begin
                 acc = 1'b1;
                 if (!at_end) w_step = 1'b1;
               end
      default: ;
    endcase
  end

  xp_walker #(.AW(AW)) u_walker (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (accept),
    .rev_i    (reverse_i),
    .base_i   (base_i),
    .last_i   (last_i),
    .clr_i    (w_clr),
    .tail_i   (w_tail),
    .step_i   (w_step),
    .addr_o   (walk_addr),
    .at_end_o (at_end)
  );

  xp_mask #(.DW(DW)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (accept),
    .acc_i  (acc),
    .diff_i (mem_rdata_i ^ pat_sel(eidx_q)),
    .mask_o (bad_mask_o)
  );

  always_comb begin
    mem_en_o    = 1'b0;
    mem_we_o    = 1'b0;
    mem_wdata_o = '0;
    unique case (st_q)
      ST_FILL: begin mem_en_o = 1'b1; mem_we_o = 1'b1; mem_wdata_o = pat_sel(pidx_q); end
      ST_PRD, ST_PRB, ST_CRD: mem_en_o = 1'b1;
      ST_PWR:  begin mem_en_o = 1'b1; mem_we_o = 1'b1; mem_wdata_o = mem_rdata_i ^ prev_q; end
      default: ;
    endcase
  end

  assign mem_addr_o = walk_addr;
  assign busy_o     = (st_q != ST_IDLE);
  assign done_o     = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      pidx_q  <= 2'd0;
      phase_q <= 2'd0;
      eidx_q  <= 2'd0;
      pass_q  <= 1'b0;
      rb_q    <= 1'b0;
      prev_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (accept) begin
          st_q   <= ST_FILL;
          pidx_q <= 2'd0;
        end
        ST_FILL: begin
          pidx_q <= mod3_inc(pidx_q);
          if (at_end) begin
            phase_q <= mod3_inc(pidx_q);
            pass_q  <= 1'b0;
            prev_q  <= PAT1;
            rb_q    <= 1'b0;
            st_q    <= ST_PRD;
          end
        end
        ST_PRD: begin
          if (rb_q) prev_q <= mem_rdata_i;
          st_q <= ST_PWR;
        end
        ST_PWR: begin
          if (at_end) begin
            if (!pass_q) begin
              pass_q <= 1'b1;
              prev_q <= PAT0;
              rb_q   <= 1'b0;
              st_q   <= ST_PRD;
            end else begin
              eidx_q <= mod3_inc(phase_q);
              st_q   <= ST_CRD;
            end
          end else begin
            st_q <= ST_PRB;
          end
        end
        ST_PRB: begin
          rb_q <= 1'b1;
          st_q <= ST_PRD;
        end
        ST_CRD: st_q <= ST_CACC;
        ST_CACC: begin
          eidx_q <= mod3_inc(eidx_q);
          if (at_end) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            st_q <= ST_CRD;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R3
  rd_before_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o && st_q == ST_PWR) |->
      ($past(mem_en_o) && !$past(mem_we_o) && ($past(mem_addr_o) == mem_addr_o)));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  // R7
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(bad_mask_o));

  // R10
  refuse_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i && !region_ok) |=> (!busy_o && !mem_en_o));

endmodule

// File: tb/xorprop_bist_bench.sv
module xorprop_bist_bench;

  localparam int AW    = 10;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0, reverse_i = 1'b0;
  logic [AW-1:0] base_i = '0, last_i = '0;
  logic          busy_o, done_o, mem_en_o, mem_we_o;
  logic [31:0]   bad_mask_o, mem_wdata_o, mem_rdata_i;
  logic [AW-1:0] mem_addr_o;

  always #4 clk = ~clk;

  xorprop_bist #(.AW(AW)) u_xorprop_bist (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .reverse_i(reverse_i),
    .base_i(base_i), .last_i(last_i), .busy_o(busy_o), .done_o(done_o),
    .bad_mask_o(bad_mask_o), .mem_en_o(mem_en_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i)
  );

  int nchk = 0, nfail = 0;
  bit finished = 0;

  // behavioural RAM with one injectable stuck-at cell
  logic [31:0] ram [DEPTH];
  logic [31:0] sh  [DEPTH];
  int          f_addr = -1;
  logic [31:0] f_sa0 = '0, f_sa1 = '0;

  function automatic logic [31:0] faulty(int a, logic [31:0] d);
    return (a == f_addr) ? ((d & ~f_sa0) | f_sa1) : d;
  endfunction

  always @(posedge clk) begin
    if (mem_en_o) begin
      if (mem_we_o) ram[mem_addr_o] <= faulty(int'(mem_addr_o), mem_wdata_o);
      else          mem_rdata_i <= ram[mem_addr_o];
    end
  end

  logic [31:0] pats [3] = '{32'h6DB6DB6D, 32'hB6DB6DB6, 32'hDB6DB6DB};

  typedef struct packed {
    logic          we;
    logic [AW-1:0] addr;
    logic [31:0]   data;
    logic [3:0]    tag;
  } op_t;
  op_t exp_q[$];

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", req, act, expv);
    end
  endtask

  function automatic void push(bit we, int a, logic [31:0] d, int tag);
    op_t o;
    o.we = we; o.addr = AW'(a); o.data = d; o.tag = 4'(tag);
    exp_q.push_back(o);
  endfunction

  // reference: R1 fill, R2/R3 propagation with read-back, R4 check, R5 mirror
  task automatic build_ref(int b, int l, bit rev, output logic [31:0] m);
    int n;
    logic [31:0] prev, v;
    n = l - b + 1;
    for (int k = 0; k < n; k++) begin
      int a = rev ? l - k : b + k;
      push(1, a, pats[k % 3], rev ? 5 : 1);
      sh[a] = faulty(a, pats[k % 3]);
    end
    for (int p = 0; p < 2; p++) begin
      prev = (p == 0) ? pats[1] : pats[0];
      for (int k = 0; k < n; k++) begin
        int a = rev ? l - k : b + k;
        push(0, a, '0, 3);
        v = sh[a] ^ prev;
        push(1, a, v, 2);
        sh[a] = faulty(a, v);
        if (k != n - 1) push(0, a, '0, 3);
        prev = sh[a];
      end
    end
    m = '0;
    for (int k = n - 3; k < n; k++) begin
      int a = rev ? l - k : b + k;
      push(0, a, '0, 4);
      m |= sh[a] ^ pats[(k + 1) % 3];
    end
  endtask

  // per-clock comparison of the memory port against the reference stream
  always @(negedge clk) begin
    op_t e;
    if (rst_n && mem_en_o && !finished) begin
      nchk++;
      if (exp_q.size() == 0) begin
        nfail++;
        $display("FAIL R10 unexpected access act=%h exp=none", mem_addr_o);
      end else begin
        e = exp_q.pop_front();
        if (e.we !== mem_we_o || e.addr !== mem_addr_o || (e.we && e.data !== mem_wdata_o)) begin
          nfail++;
          $display("FAIL R%0d op act=%b/%h/%h exp=%b/%h/%h", e.tag,
                   mem_we_o, mem_addr_o, mem_wdata_o, e.we, e.addr, e.data);
        end
      end
    end
  end

  task automatic run(int b, int l, bit rev, bit poke, string req);
    logic [31:0] em;
    int n, cnt, wd;
    n = l - b + 1;
    build_ref(b, l, rev, em);
    @(negedge clk);
    start_i = 1; base_i = AW'(b); last_i = AW'(l); reverse_i = rev;
    @(negedge clk);
    start_i = 0;
    chk(busy_o === 1'b1, "R7 busy after start", 32'(busy_o), 1);
    chk(bad_mask_o === 32'h0, "R9 mask cleared", bad_mask_o, 0);
    cnt = 0; wd = 0;
    while (!done_o && wd < 20000) begin
      if (busy_o) cnt++;
      if (poke && cnt == 10) begin
        // R8: start while busy, different region and direction
        start_i = 1; base_i = 0; last_i = 40; reverse_i = !rev;
      end else start_i = 0;
      @(negedge clk);
      wd++;
    end
    start_i = 0;
    chk(wd < 20000, "R11 run ended", wd, 0);
    chk(cnt == 7 * n + 4, "R11 busy cycles", cnt, 7 * n + 4);
    chk(bad_mask_o === em, req, bad_mask_o, em);
    chk(exp_q.size() == 0, "R2 all ops issued", exp_q.size(), 0);
    chk(busy_o === 1'b0, "R7 idle at done", 32'(busy_o), 0);
    @(negedge clk);
    chk(done_o === 1'b0, "R7 done one cycle", 32'(done_o), 0);
    repeat (3) @(negedge clk);
    chk(bad_mask_o === em, "R7 mask held", bad_mask_o, em);
    exp_q.delete();
  endtask

  task automatic refuse(int b, int l);
    logic [31:0] mv;
    mv = bad_mask_o;
    @(negedge clk);
    start_i = 1; base_i = AW'(b); last_i = AW'(l); reverse_i = 0;
    @(negedge clk);
    start_i = 0;
    repeat (4) begin
      chk(busy_o === 1'b0, "R10 start refused", 32'(busy_o), 0);
      @(negedge clk);
    end
    chk(bad_mask_o === mv, "R10 mask kept", bad_mask_o, mv);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      nfail++;
      $display("FAIL R11 watchdog act=running exp=finished");
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) ram[i] = 32'hA5A5_0000 + 32'(i);
    repeat (3) @(negedge clk);
    chk(busy_o === 1'b0 && done_o === 1'b0, "R7 reset idle", {busy_o, done_o}, 0);
    chk(bad_mask_o === 32'h0, "R9 reset mask", bad_mask_o, 0);
    rst_n = 1;
    @(negedge clk);
    chk(mem_en_o === 1'b0, "R10 no access after reset", 32'(mem_en_o), 0);

    // R4: each phase of N mod 3, upward
    run(16, 21, 0, 0, "R4 mask clean N=6");
    run(100, 106, 0, 0, "R4 mask clean N=7");
    run(200, 207, 0, 0, "R4 mask clean N=8");
    // R5: downward walks
    run(300, 307, 1, 0, "R5 mask clean rev N=8");
    run(310, 318, 1, 0, "R5 mask clean rev N=9");

    // R6: stuck-at-0 on bit 1 of the last word (expected bit is 1)
    f_addr = 409; f_sa0 = 32'h0000_0002; f_sa1 = '0;
    run(400, 409, 0, 0, "R6 direct fault mask");
    chk(bad_mask_o[1] === 1'b1, "R6 fault bit reported", bad_mask_o, 32'h2);

    // R9: clean run after a faulty one
    f_addr = -1; f_sa0 = '0;
    run(420, 431, 0, 0, "R9 mask after clean run");

    // R6: fault early in a downward walk, reaches check through the chain
    f_addr = 519; f_sa1 = 32'h0000_0100;
    run(500, 520, 1, 0, "R6 chained fault mask");
    f_addr = -1; f_sa1 = '0;

    // R8: start pulse in mid-run
    run(600, 615, 0, 1, "R8 run unaffected by start");

    // R10: too short and inverted regions
    refuse(700, 704);
    refuse(710, 705);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule